// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block sits in the execute stage of a five-stage in-order pipeline. For each of the two ALU operands it picks the freshest copy of the source register. The candidates are the value read from the register file and held in the decode/execute register, the ALU result held in the execute/memory register, and the write-back value held in the memory/write-back register. The block produces a two-bit select for each operand and also drives the operand multiplexers on a configurable data width.

The rule is that the youngest producer wins. A match in the execute/memory stage overrides a match in the memory/write-back stage. A writer that has already left write-back needs no path. The register file writes in the first half of a cycle and reads in the second half, so the register read already sees that value. The hardwired zero register is never forwarded. The logic is purely combinational, so the selects and operands follow the inputs within the same cycle.

Top module: `opnd_fwd_unit`

## Requirements
- R1: When neither later stage matches an operand, that operand's select is 2'b00 and the operand equals its register-file value.
- R2: When the execute/memory write enable is 1 and its destination index equals the operand's source index, the select is 2'b10 and the operand equals the execute/memory result.
- R3: When only the memory/write-back stage has its write enable at 1 and a destination index equal to the operand's source index, the select is 2'b01 and the operand equals the write-back data.
- R4: When both stages match the same operand, the select is 2'b10 and the execute/memory result is used.
- R5: A stage whose write enable is 0 never causes forwarding, whatever its destination index is.
- R6: A destination index equal to the zero register (index 31 by default) is never forwarded. The register-file value is used instead.
- R7: Operand A and operand B are resolved independently by the same rules. Each has its own select and its own result.
- R8: A select never takes the value 2'b11.
- R9: Each operand output always equals the source named by its own select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a_i | input | AW (5) | Source register index of operand A, held in decode/execute |
| ex_src_b_i | input | AW (5) | Source register index of operand B, held in decode/execute |
| ex_rf_a_i | input | XLEN (64) | Register-file value for operand A |
| ex_rf_b_i | input | XLEN (64) | Register-file value for operand B |
| exm_we_i | input | 1 | Execute/memory stage will write a register |
| exm_dst_i | input | AW (5) | Execute/memory destination index |
| exm_res_i | input | XLEN (64) | Execute/memory ALU result |
| mwb_we_i | input | 1 | Memory/write-back stage will write a register |
| mwb_dst_i | input | AW (5) | Memory/write-back destination index |
| mwb_data_i | input | XLEN (64) | Memory/write-back value |
| sel_a_o | output | 2 | Operand A select (00 register file, 10 execute/memory, 01 memory/write-back) |
| sel_b_o | output | 2 | Operand B select, same encoding |
| opnd_a_o | output | XLEN (64) | Forwarded operand A |
| opnd_b_o | output | XLEN (64) | Forwarded operand B |

## Verification
The hardest case to reach is one where both later stages write the very register an operand reads, both enables are set, and the other operand takes a different path in the same cycle. Uniform 5-bit indices almost never line up like that. The random stimulus therefore draws every index from a pool of four ordinary registers plus the zero register, so double matches, zero-register writes and mixed A/B outcomes all occur often. Directed cases pin down each combination of both matching, only one matching with the other enable cleared, and the zero register with both stages writing it.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_MWB   = 2'b01,
    FWD_EXM   = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int AW       = 5,
  parameter int ZERO_IDX = 31
) (
  input  logic          we_i,
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] src_i,
  output logic          hit_o
);
  localparam logic [AW-1:0] ZeroReg = AW'(ZERO_IDX);

  // A writer only counts when it really writes a non-zero register.
  always_comb begin
    hit_o = we_i && (dst_i == src_i) && (dst_i != ZeroReg);
  end
endmodule

// File: rtl/fwd_prio.sv
module fwd_prio
  import fwd_pkg::*;
(
  input  logic     hit_exm_i,
  input  logic     hit_mwb_i,
  output fwd_sel_e sel_o
);
  // The younger stage is tested first.
  always_comb begin
    if (hit_exm_i)      sel_o = FWD_EXM;
    else if (hit_mwb_i) sel_o = FWD_MWB;
    else                sel_o = FWD_RF;
  end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  fwd_sel_e        sel_i,
  input  logic [XLEN-1:0] rf_i,
  input  logic [XLEN-1:0] exm_i,
  input  logic [XLEN-1:0] mwb_i,
  output logic [XLEN-1:0] data_o
);
  always_comb begin
    unique case (sel_i)
      FWD_EXM: data_o = exm_i;
      FWD_MWB: data_o = mwb_i;
      default: data_o = rf_i;
    endcase
  end
endmodule

// File: rtl/opnd_fwd_unit.sv
module opnd_fwd_unit
  import fwd_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int AW       = 5,
  parameter int ZERO_IDX = 31
) (
  input  logic [AW-1:0]   ex_src_a_i,
  input  logic [AW-1:0]   ex_src_b_i,
  input  logic [XLEN-1:0] ex_rf_a_i,
  input  logic [XLEN-1:0] ex_rf_b_i,
  input  logic            exm_we_i,
  input  logic [AW-1:0]   exm_dst_i,
  input  logic [XLEN-1:0] exm_res_i,
  input  logic            mwb_we_i,
  input  logic [AW-1:0]   mwb_dst_i,
  input  logic [XLEN-1:0] mwb_data_i,
  output logic [1:0]      sel_a_o,
  output logic [1:0]      sel_b_o,
  output logic [XLEN-1:0] opnd_a_o,
  output logic [XLEN-1:0] opnd_b_o
);
  localparam int NumOpnd = 2;

  logic [NumOpnd-1:0][AW-1:0]   src_idx;
  logic [NumOpnd-1:0][XLEN-1:0] rf_val;
  logic [NumOpnd-1:0][XLEN-1:0] res_val;
  fwd_sel_e                     sel_q [NumOpnd];

  assign src_idx[0] = ex_src_a_i;
  assign src_idx[1] = ex_src_b_i;
  assign rf_val[0]  = ex_rf_a_i;
  assign rf_val[1]  = ex_rf_b_i;

  for (genvar g = 0; g < NumOpnd; g++) begin : g_opnd
    logic hit_exm;
    logic hit_mwb;

    fwd_hit #(.AW(AW), .ZERO_IDX(ZERO_IDX)) u_hit_exm (
      .we_i (exm_we_i),
      .dst_i(exm_dst_i),
      .src_i(src_idx[g]),
      .hit_o(hit_exm)
    );

    fwd_hit #(.AW(AW), .ZERO_IDX(ZERO_IDX)) u_hit_mwb (
      .we_i (mwb_we_i),
      .dst_i(mwb_dst_i),
      .src_i(src_idx[g]),
      .hit_o(hit_mwb)
    );

    fwd_prio u_prio (
      .hit_exm_i(hit_exm),
      .hit_mwb_i(hit_mwb),
      .sel_o    (sel_q[g])
    );

    fwd_mux #(.XLEN(XLEN)) u_mux (
      .sel_i (sel_q[g]),
      .rf_i  (rf_val[g]),
      .exm_i (exm_res_i),
      .mwb_i (mwb_data_i),
      .data_o(res_val[g])
    );
  end

  assign sel_a_o  = sel_q[0];
  assign sel_b_o  = sel_q[1];
  assign opnd_a_o = res_val[0];
  assign opnd_b_o = res_val[1];
endmodule

// File: rtl/opnd_fwd_chk.sv
module opnd_fwd_chk #(
  parameter int XLEN     = 64,
  parameter int AW       = 5,
  parameter int ZERO_IDX = 31
) (
  input logic [AW-1:0]   ex_src_a_i,
  input logic [AW-1:0]   ex_src_b_i,
  input logic [XLEN-1:0] ex_rf_a_i,
  input logic [XLEN-1:0] ex_rf_b_i,
  input logic            exm_we_i,
  input logic [AW-1:0]   exm_dst_i,
  input logic [XLEN-1:0] exm_res_i,
  input logic            mwb_we_i,
  input logic [AW-1:0]   mwb_dst_i,
  input logic [XLEN-1:0] mwb_data_i,
  input logic [1:0]      sel_a_o,
  input logic [1:0]      sel_b_o,
  input logic [XLEN-1:0] opnd_a_o,
  input logic [XLEN-1:0] opnd_b_o
);
  localparam logic [AW-1:0] ZeroReg = AW'(ZERO_IDX);

  logic known;
  assign known = !$isunknown({ex_src_a_i, ex_src_b_i, exm_we_i, exm_dst_i,
                              mwb_we_i, mwb_dst_i, sel_a_o, sel_b_o});

  always_comb begin
    if (known) begin
      // R8
      sel_a_legal_chk: assert (sel_a_o != 2'b11);
      // R8
      sel_b_legal_chk: assert (sel_b_o != 2'b11);
      // R4
      exm_prio_chk: assert (!(exm_we_i && exm_dst_i == ex_src_a_i &&
                              exm_dst_i != ZeroReg) || sel_a_o == 2'b10);
      // R5
      we_gate_chk: assert (sel_a_o != 2'b10 || exm_we_i);
      // R6
      zero_reg_chk: assert (ex_src_b_i != ZeroReg || sel_b_o == 2'b00);
      // R9
      mux_a_chk: assert (sel_a_o != 2'b01 || opnd_a_o == mwb_data_i);
      // R9
      mux_b_chk: assert (sel_b_o != 2'b00 || opnd_b_o == ex_rf_b_i);
    end
  end
endmodule

bind opnd_fwd_unit opnd_fwd_chk #(.XLEN(XLEN), .AW(AW), .ZERO_IDX(ZERO_IDX)) chk_i (
  .ex_src_a_i(ex_src_a_i), .ex_src_b_i(ex_src_b_i),
  .ex_rf_a_i(ex_rf_a_i),   .ex_rf_b_i(ex_rf_b_i),
  .exm_we_i(exm_we_i),     .exm_dst_i(exm_dst_i), .exm_res_i(exm_res_i),
  .mwb_we_i(mwb_we_i),     .mwb_dst_i(mwb_dst_i), .mwb_data_i(mwb_data_i),
  .sel_a_o(sel_a_o),       .sel_b_o(sel_b_o),
  .opnd_a_o(opnd_a_o),     .opnd_b_o(opnd_b_o)
);

// File: tb/opnd_fwd_unit_tb_top.sv
module opnd_fwd_unit_tb_top;
  localparam int XLEN = 64;
  localparam int AW   = 5;
  localparam int ZR   = 31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0]   src_a, src_b, exm_dst, mwb_dst;
  logic [XLEN-1:0] rf_a, rf_b, exm_res, mwb_data;
  logic            exm_we, mwb_we;
  logic [1:0]      sel_a, sel_b;
  logic [XLEN-1:0] op_a, op_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  opnd_fwd_unit #(.XLEN(XLEN), .AW(AW), .ZERO_IDX(ZR)) dut_i (
    .ex_src_a_i(src_a), .ex_src_b_i(src_b), .ex_rf_a_i(rf_a), .ex_rf_b_i(rf_b),
    .exm_we_i(exm_we), .exm_dst_i(exm_dst), .exm_res_i(exm_res),
    .mwb_we_i(mwb_we), .mwb_dst_i(mwb_dst), .mwb_data_i(mwb_data),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .opnd_a_o(op_a), .opnd_b_o(op_b)
  );

  function automatic logic [1:0] exp_sel(logic [AW-1:0] src);
    if (exm_we && exm_dst == src && exm_dst != AW'(ZR)) return 2'b10;
    if (mwb_we && mwb_dst == src && mwb_dst != AW'(ZR)) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [XLEN-1:0] exp_val(logic [1:0] s, logic [XLEN-1:0] rf);
    if (s == 2'b10) return exm_res;
    if (s == 2'b01) return mwb_data;
    return rf;
  endfunction

  function automatic logic [XLEN-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    logic [1:0] ea, eb;
    @(posedge clk);
    #1;
    ea = exp_sel(src_a);
    eb = exp_sel(src_b);
    check({req, " sel_a"}, XLEN'(sel_a), XLEN'(ea));
    check({req, " sel_b"}, XLEN'(sel_b), XLEN'(eb));
    check({req, " opnd_a"}, op_a, exp_val(ea, rf_a));
    check({req, " opnd_b"}, op_b, exp_val(eb, rf_b));
  endtask

  task automatic drive(logic [AW-1:0] a, logic [AW-1:0] b, logic we1, logic [AW-1:0] d1,
                       logic we2, logic [AW-1:0] d2);
    @(negedge clk);
    src_a = a; src_b = b; exm_we = we1; exm_dst = d1; mwb_we = we2; mwb_dst = d2;
    rf_a = rnd64(); rf_b = rnd64(); exm_res = rnd64(); mwb_data = rnd64();
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    src_a = '0; src_b = '0; exm_dst = '0; mwb_dst = '0;
    rf_a = 64'h1111; rf_b = 64'h2222; exm_res = 64'h3333; mwb_data = 64'h4444;
    exm_we = 1'b0; mwb_we = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 idle state: register-file values pass through
    @(posedge clk); #1;
    check("R1 idle sel_a", XLEN'(sel_a), '0);
    check("R1 idle opnd_a", op_a, 64'h1111);
    check("R1 idle opnd_b", op_b, 64'h2222);
    // R2 execute/memory match on A only
    drive(5'd3, 5'd4, 1'b1, 5'd3, 1'b0, 5'd0); check_all("R2");
    check("R2 sel_a direct", XLEN'(sel_a), XLEN'(2'b10));
    // R3 memory/write-back match on B only
    drive(5'd3, 5'd4, 1'b0, 5'd3, 1'b1, 5'd4); check_all("R3");
    check("R3 sel_b direct", XLEN'(sel_b), XLEN'(2'b01));
    // R4 both match both operands
    drive(5'd7, 5'd7, 1'b1, 5'd7, 1'b1, 5'd7); check_all("R4");
    check("R4 opnd_a direct", op_a, exm_res);
    // R5 enables low with matching indices
    drive(5'd9, 5'd9, 1'b0, 5'd9, 1'b0, 5'd9); check_all("R5");
    check("R5 opnd_b direct", op_b, rf_b);
    // R6 zero register written by both stages
    drive(5'd31, 5'd31, 1'b1, 5'd31, 1'b1, 5'd31); check_all("R6");
    check("R6 sel_a direct", XLEN'(sel_a), '0);
    // R7 A from execute/memory, B from write-back
    drive(5'd1, 5'd2, 1'b1, 5'd1, 1'b1, 5'd2); check_all("R7");
    check("R7 sel_b direct", XLEN'(sel_b), XLEN'(2'b01));
    // R8 R9 random mix over a narrow register pool
    for (int i = 0; i < 500; i++) begin
      logic [AW-1:0] pool [5];
      pool[0] = 5'd1; pool[1] = 5'd2; pool[2] = 5'd3; pool[3] = 5'd4; pool[4] = 5'd31;
      drive(pool[$urandom_range(4)], pool[$urandom_range(4)], 1'($urandom()),
            pool[$urandom_range(4)], 1'($urandom()), pool[$urandom_range(4)]);
      check_all("R8 R9 random");
      check("R8 sel legal", XLEN'(sel_a == 2'b11 || sel_b == 2'b11), '0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule